// File: doc/BRIEF.md
# Shopping Budget Setup Sequencer

This controller runs once, before a shopping session begins. Each clock it reads one decision bit and steps through a fixed four-phase Mealy machine. The machine has one combinational decision output. The last phase is absorbing: once the machine reaches it, only a reset leaves it. The transition into that final phase is the moment of commitment. On that cycle the block picks a candidate budget. If the shopper chose to skip entry, the candidate is the full account balance. Otherwise it is the typed amount. The block then compares the candidate with the balance.

A candidate that fits is written into a 30-bit budget register, and a sticky valid flag is raised. A candidate that exceeds the balance raises a sticky error flag instead, and the register keeps its cleared value. The balance and the requested amount are presented as ready parallel inputs. The block does not talk to the card or the database, and it does not drive the keypad or the display.

Top module: `budget_setup_seq`

## Requirements
- R1: A synchronous active-high `rst` puts `phase` at 0 (idle) and clears `budget`, `budget_valid` and `budget_err` on the next clock edge.
- R2: In phase 0, `dec_bit`=0 keeps phase 0 and `dec_bit`=1 moves to phase 1. In both cases `dec_out` is 0.
- R3: In phase 1, `dec_bit`=0 moves to phase 2 with `dec_out`=0, and `dec_bit`=1 moves to phase 3 with `dec_out`=1.
- R4: In phase 2, `dec_bit`=0 returns to phase 0 with `dec_out`=0, and `dec_bit`=1 moves to phase 3 with `dec_out`=1.
- R5: Phase 3 is absorbing. For either value of `dec_bit` the phase stays 3 and `dec_out` is 1.
- R6: On the edge that enters phase 3, if `skip_entry`=1, `budget` loads `acct_balance` and `budget_valid` goes to 1. The value of `req_budget` is ignored.
- R7: On that same edge with `skip_entry`=0, a `req_budget` less than or equal to `acct_balance` is loaded into `budget` and `budget_valid` goes to 1. This includes the case where the two are equal.
- R8: On that same edge with `skip_entry`=0, a `req_budget` greater than `acct_balance` sets `budget_err`. In that case `budget` stays 0 and `budget_valid` stays 0.
- R9: `budget` changes only on the edge that enters phase 3. In particular, balance and request changes while the block sits in phase 3 leave it unchanged.
- R10: `budget_valid` and `budget_err` are never both 1. Once set, each holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_bit | input | 1 | Serial decision bit, one per clock |
| skip_entry | input | 1 | 1: use the whole balance as the budget |
| acct_balance | input | 30 | Account balance |
| req_budget | input | 30 | Budget typed by the shopper |
| dec_out | output | 1 | Mealy decision output |
| phase | output | 2 | Current phase, 0 to 3 |
| budget | output | 30 | Stored budget |
| budget_valid | output | 1 | Budget accepted and stored |
| budget_err | output | 1 | Requested budget exceeded the balance |

## Verification
The assertions check the following on every cycle:
- each transition of the phase table and the output it produces;
- that phase 3 is absorbing;
- the reset values;
- that the budget register is stable outside the commit edge;
- that valid and error are mutually exclusive.

Only the bench scenarios can show which value the commit edge stores. That covers the skip path versus the typed path, a request exactly equal to the balance, a request one above it, and the 30-bit extremes. The comparison is checked against a bench model fed with random walks of decision bits.

// File: rtl/budget_setup_seq.sv
module budget_setup_seq #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec_bit,
  input  logic         skip_entry,
  input  logic [W-1:0] acct_balance,
  input  logic [W-1:0] req_budget,
  output logic         dec_out,
  output logic [1:0]   phase,
  output logic [W-1:0] budget,
  output logic         budget_valid,
  output logic         budget_err
);
  typedef enum logic [1:0] {IDLE = 2'd0, CHOOSE = 2'd1, RETRY = 2'd2, LOCKED = 2'd3} phase_t;

  phase_t cur, nxt;
  logic [W-1:0] cand;
  logic commit, fits;

  always_comb begin
    nxt = cur;
    unique case (cur)
      IDLE:   nxt = dec_bit ? CHOOSE : IDLE;
      CHOOSE: nxt = dec_bit ? LOCKED : RETRY;
      RETRY:  nxt = dec_bit ? LOCKED : IDLE;
      LOCKED: nxt = LOCKED;
    endcase
  end

  assign dec_out = (cur == LOCKED) | (dec_bit & (cur != IDLE));
  assign commit  = dec_bit & ((cur == CHOOSE) | (cur == RETRY));
  assign cand    = skip_entry ? acct_balance : req_budget;
  assign fits    = cand <= acct_balance;
  assign phase   = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur          <= IDLE;
      budget       <= '0;
      budget_valid <= 1'b0;
      budget_err   <= 1'b0;
    end else begin
      cur <= nxt;
      if (commit && fits) begin
        budget       <= cand;
        budget_valid <= 1'b1;
      end
      if (commit && !fits) budget_err <= 1'b1;
    end
  end
endmodule

// File: rtl/budget_setup_seq_chk.sv
module budget_setup_seq_chk #(
  parameter int W = 30
) (
  input logic         clk,
  input logic         rst,
  input logic         dec_bit,
  input logic         dec_out,
  input logic [1:0]   phase,
  input logic [W-1:0] budget,
  input logic         budget_valid,
  input logic         budget_err
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (phase == 2'd0 && budget == '0 && !budget_valid && !budget_err)); // R1
  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (rst) (phase == 2'd0 && !dec_bit) |=> phase == 2'd0); // R2
  AST_IDLE_GO:     assert property (@(posedge clk) disable iff (rst) (phase == 2'd0 && dec_bit) |=> phase == 2'd1); // R2
  AST_IDLE_ZERO:   assert property (@(posedge clk) disable iff (rst) phase == 2'd0 |-> !dec_out); // R2
  AST_CHOOSE_NXT:  assert property (@(posedge clk) disable iff (rst) phase == 2'd1 |=> phase == ($past(dec_bit) ? 2'd3 : 2'd2)); // R3
  AST_RETRY_NXT:   assert property (@(posedge clk) disable iff (rst) phase == 2'd2 |=> phase == ($past(dec_bit) ? 2'd3 : 2'd0)); // R4
  AST_MID_OUT:     assert property (@(posedge clk) disable iff (rst) (phase == 2'd1 || phase == 2'd2) |-> dec_out == dec_bit); // R3
  AST_LOCK_STAY:   assert property (@(posedge clk) disable iff (rst) phase == 2'd3 |=> phase == 2'd3); // R5
  AST_LOCK_OUT:    assert property (@(posedge clk) disable iff (rst) phase == 2'd3 |-> dec_out); // R5
  AST_BUDGET_HOLD: assert property (@(posedge clk) disable iff (rst) !((phase == 2'd1 || phase == 2'd2) && dec_bit) |=> $stable(budget)); // R9
  AST_FLAG_EXCL:   assert property (@(posedge clk) disable iff (rst) !(budget_valid && budget_err)); // R10
  AST_VALID_STICK: assert property (@(posedge clk) disable iff (rst) budget_valid |=> budget_valid); // R10
  AST_ERR_STICK:   assert property (@(posedge clk) disable iff (rst) budget_err |=> budget_err); // R8
endmodule

bind budget_setup_seq budget_setup_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dec_bit(dec_bit), .dec_out(dec_out), .phase(phase),
  .budget(budget), .budget_valid(budget_valid), .budget_err(budget_err)
);

// File: tb/budget_setup_seq_test.sv
module budget_setup_seq_test;
  localparam int W = 30;
  logic clk = 0, rst = 1, dec_bit = 0, skip_entry = 0;
  logic [W-1:0] acct_balance = '0, req_budget = '0;
  logic dec_out, budget_valid, budget_err;
  logic [1:0] phase;
  logic [W-1:0] budget;

  int checks = 0, errors = 0;
  logic [1:0] m_ph;
  logic [W-1:0] m_bud;
  logic m_val, m_err;

  budget_setup_seq #(.W(W)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [1:0] nxt_ph(input logic [1:0] p, input logic x);
    case (p)
      2'd0: return x ? 2'd1 : 2'd0;
      2'd1: return x ? 2'd3 : 2'd2;
      2'd2: return x ? 2'd3 : 2'd0;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic exp_z(input logic [1:0] p, input logic x);
    return (p == 2'd3) || (x && p != 2'd0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk({req, " phase"}, phase, m_ph);
    chk({req, " budget"}, budget, m_bud);
    chk({req, " valid"}, budget_valid, m_val);
    chk({req, " err"}, budget_err, m_err);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1 rst = 0;
    m_ph = 0; m_bud = 0; m_val = 0; m_err = 0;
    check_regs("R1");
  endtask

  task automatic step(input logic x, input logic sk, input logic [W-1:0] bal, input logic [W-1:0] rq, input string req);
    logic [W-1:0] c;
    @(negedge clk);
    dec_bit = x; skip_entry = sk; acct_balance = bal; req_budget = rq;
    #1 chk({req, " dec_out"}, dec_out, exp_z(m_ph, x));
    if ((m_ph == 2'd1 || m_ph == 2'd2) && x) begin
      c = sk ? bal : rq;
      if (c <= bal) begin m_bud = c; m_val = 1; end
      else m_err = 1;
    end
    m_ph = nxt_ph(m_ph, x);
    @(posedge clk);
    #1 check_regs(req);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R2/R3/R4 walk: hold, go, retry, back to idle
    step(0, 0, 30'd100, 30'd50, "R2");
    step(1, 0, 30'd100, 30'd50, "R2");
    step(0, 0, 30'd100, 30'd50, "R3");
    step(0, 0, 30'd100, 30'd50, "R4");
    step(1, 0, 30'd100, 30'd50, "R2");
    step(0, 0, 30'd100, 30'd50, "R3");
    step(1, 0, 30'd100, 30'd100, "R7 equal via R4");
    step(0, 0, 30'd5, 30'd1, "R5 R9");
    step(1, 1, 30'd7, 30'd2, "R5 R9");
    // R8 one above
    do_reset();
    step(1, 0, 30'd200, 30'd201, "R2");
    step(1, 0, 30'd200, 30'd201, "R8");
    step(1, 0, 30'd300, 30'd1, "R10 R9");
    // R6 skip with huge request
    do_reset();
    step(1, 1, 30'h3FFF_FFFF, 30'h3FFF_FFFF, "R2");
    step(1, 1, 30'h3FFF_FFFF, 30'h3FFF_FFFE, "R6");
    step(0, 0, 30'd0, 30'd9, "R9");
    do_reset();
    step(1, 1, 30'd12, 30'h3FFF_FFFF, "R2");
    step(1, 1, 30'd12, 30'h3FFF_FFFF, "R6 request ignored");
    // random walks
    for (int e = 0; e < 60; e++) begin
      do_reset();
      for (int s = 0; s < 14; s++) begin
        logic [W-1:0] b, r;
        b = W'($urandom);
        case ($urandom_range(0, 3))
          0: r = b;
          1: r = b + 30'd1;
          default: r = W'($urandom);
        endcase
        step(1'($urandom), 1'($urandom_range(0, 3) == 0), b, r, "R7 R8 random");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule